// File: doc/BRIEF.md
# Crypto Engine Command Queue Interpreter

The block sits between a host and a block-cipher engine. The host pushes 32-bit command words into a five-entry inbound queue. An interpreter drains that queue one word at a time and turns each command into an action. It can latch a source address for the cipher, start the cipher for a number of 16-byte blocks, flag a transfer-complete event, run a word-by-word copy between external memory and the engine's internal RAM, or load a key table into a numbered slot. Commands that take an operand absorb the word that follows them, and that word is never decoded as a command.

The cipher core and the memory port are outside the block. Each is reached through a plain handshake. The cipher receives a start pulse and answers with a done pulse. The memory port sees a held request and answers with one acknowledge per word. The host paces its writes using the engine-busy, queue-empty and DMA-busy flags. Events are collected in a sticky interrupt status vector, which has an enable mask and is cleared by writing ones.

Top module: `cq_interp`

## Requirements
- R1: After reset the queue is empty, all busy flags are low, the interrupt status is zero and `irq_o` is low.
- R2: The queue holds 5 words. A write while the queue is full is dropped and sets interrupt status bit 1 (overflow).
- R3: The opcode is bits [31:26]. Opcode 0x10 makes the next queued word the cipher source address, which appears on `eng_src_o`. That word is not decoded, even when its top bits match a valid opcode.
- R4: Opcode 0x0E pulses `eng_start_o` for one cycle, with `eng_nblk_o` equal to bits [11:0] plus one. `eng_busy_o` then stays high, and no further word is decoded, until `eng_done_i`.
- R5: Opcode 0x11 sets interrupt status bit 4 (transfer complete).
- R6: Opcode 0x22 takes its direction from bit 25 (0 = external to internal RAM) and its word count from bits [24:12]. The next word is the memory address. `mdma_req_o` is held until that many `mdma_ack_i` cycles have occurred. `dma_busy_o` is high from acceptance of the command until the last acknowledge. The end of the copy sets interrupt status bit 5. A count of zero finishes as soon as the address word is taken.
- R7: Opcode 0x15 carries a table select at bit 24, an internal-RAM select at bit 23, and a 4-bit key id at bits [20:17] formed as 8 OR slot. With bit 20 set, it pulses `key_load_o` with the slot from bits [19:17] and the two selects. With bit 20 clear, it sets status bit 0 and no load occurs.
- R8: Any other opcode sets interrupt status bit 0. The word is discarded and the queue keeps draining.
- R9: Status bits are sticky. `irq_clr_i` clears every bit that is set in `irq_clr_mask_i`, and a new event in the same cycle wins over the clear. `irq_o` is the OR of status ANDed with `irq_en_i`.
- R10: `q_empty_o` is high exactly when no word is queued. `eng_busy_o` is high whenever the interpreter is waiting for an operand, the cipher or the memory copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host writes a command word |
| cmd_data_i | input | 32 | Command word |
| irq_en_i | input | 8 | Interrupt enable mask |
| irq_clr_i | input | 1 | Write-one-to-clear strobe |
| irq_clr_mask_i | input | 8 | Bits to clear |
| eng_busy_o | output | 1 | Interpreter busy |
| q_empty_o | output | 1 | Queue empty |
| dma_busy_o | output | 1 | Memory copy in progress |
| irq_stat_o | output | 8 | Interrupt status |
| irq_o | output | 1 | Masked interrupt |
| eng_start_o | output | 1 | Cipher start pulse |
| eng_nblk_o | output | 13 | Number of blocks to process |
| eng_src_o | output | 32 | Cipher source address |
| eng_done_i | input | 1 | Cipher finished |
| mdma_req_o | output | 1 | Memory copy request |
| mdma_dir_o | output | 1 | Copy direction, 1 = internal to external |
| mdma_addr_o | output | 32 | External memory address |
| mdma_ack_i | input | 1 | One word transferred |
| key_load_o | output | 1 | Key-table load pulse |
| key_slot_o | output | 3 | Key slot number |
| key_tbl_sel_o | output | 1 | Table select |
| key_ram_sel_o | output | 1 | Internal-RAM select |

## Verification
The bench targets several corner cases:

- An address operand whose top bits spell the memory-copy opcode. A decoder that fails to absorb operands would start a spurious copy.
- A burst of six key loads pushed while the cipher runs. A queue that overwrites or mis-wraps would load the wrong slots or more than five.
- Memory copies of zero words and copies with random acknowledge gaps. These expose off-by-one word counts or a DMA-busy flag that drops early.
- Unknown opcodes and malformed key ids placed ahead of valid work. These show whether errors are flagged without stalling the queue.
- Masking and write-one-to-clear of the status vector.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [5:0] {
    OP_ENG_GO    = 6'h0E,
    OP_DMA_SETUP = 6'h10,
    OP_DMA_DONE  = 6'h11,
    OP_SET_TBL   = 6'h15,
    OP_MEM_DMA   = 6'h22
  } op_e;

  localparam int OP_LSB  = 26;
  localparam int DIR_POS = 25;
  localparam int NW_LSB  = 12;
  localparam int TBL_POS = 24;
  localparam int RAM_POS = 23;
  localparam int KID_LSB = 17;

  localparam int IRQ_W    = 8;
  localparam int IRQ_BAD  = 0;
  localparam int IRQ_OVF  = 1;
  localparam int IRQ_XFER = 4;
  localparam int IRQ_MDMA = 5;

  typedef enum logic [1:0] {S_IDLE, S_OPND, S_ENG, S_MDMA} st_e;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cq_irq.sv
module cq_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[b] <= 1'b0;
      else         stat_q[b] <= set_i[b] | (stat_q[b] & ~(clr_i & clr_mask_i[b]));
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/cq_seq.sv
module cq_seq
  import cq_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int NW_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      head_i,
  input  logic             empty_i,
  output logic             pop_o,
  output logic [IRQ_W-1:0] set_o,
  output logic             busy_o,
  output logic             dma_busy_o,
  output logic             eng_start_o,
  output logic [BLK_W:0]   eng_nblk_o,
  output logic [31:0]      eng_src_o,
  input  logic             eng_done_i,
  output logic             mdma_req_o,
  output logic             mdma_dir_o,
  output logic [31:0]      mdma_addr_o,
  input  logic             mdma_ack_i,
  output logic             key_load_o,
  output logic [2:0]       key_slot_o,
  output logic             key_tbl_o,
  output logic             key_ram_o
);
  st_e             state_q;
  logic [5:0]      op;
  logic            pend_q, start_q, req_q, dir_q, dbusy_q, kld_q, tbl_q, ram_q;
  logic [BLK_W:0]  nblk_q;
  logic [31:0]     src_q, maddr_q;
  logic [NW_W-1:0] left_q;
  logic [2:0]      slot_q;

  assign op = head_i[OP_LSB +: 6];

  always_comb begin
    pop_o = 1'b0;
    set_o = '0;
    unique case (state_q)
      S_IDLE: if (!empty_i) begin
        pop_o = 1'b1;
        case (op)
          OP_ENG_GO, OP_DMA_SETUP, OP_MEM_DMA: ;
          OP_DMA_DONE: set_o[IRQ_XFER] = 1'b1;
          OP_SET_TBL:  set_o[IRQ_BAD]  = ~head_i[KID_LSB + 3];
          default:     set_o[IRQ_BAD]  = 1'b1;
        endcase
      end
      S_OPND: if (!empty_i) begin
        pop_o = 1'b1;
        set_o[IRQ_MDMA] = pend_q & (left_q == '0);
      end
      S_MDMA: set_o[IRQ_MDMA] = mdma_ack_i & (left_q == NW_W'(1));
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      nblk_q  <= '0;
      src_q   <= '0;
      req_q   <= 1'b0;
      dir_q   <= 1'b0;
      maddr_q <= '0;
      left_q  <= '0;
      dbusy_q <= 1'b0;
      kld_q   <= 1'b0;
      slot_q  <= '0;
      tbl_q   <= 1'b0;
      ram_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      kld_q   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (!empty_i) begin
          case (op)
            OP_ENG_GO: begin
              start_q <= 1'b1;
              nblk_q  <= {1'b0, head_i[BLK_W-1:0]} + (BLK_W+1)'(1);
              state_q <= S_ENG;
            end
            OP_DMA_SETUP: begin
              pend_q  <= 1'b0;
              state_q <= S_OPND;
            end
            OP_MEM_DMA: begin
              pend_q  <= 1'b1;
              dir_q   <= head_i[DIR_POS];
              left_q  <= head_i[NW_LSB +: NW_W];
              dbusy_q <= 1'b1;
              state_q <= S_OPND;
            end
            OP_SET_TBL: if (head_i[KID_LSB + 3]) begin
              kld_q  <= 1'b1;
              slot_q <= head_i[KID_LSB +: 3];
              tbl_q  <= head_i[TBL_POS];
              ram_q  <= head_i[RAM_POS];
            end
            default: ;
          endcase
        end
        S_OPND: if (!empty_i) begin
          if (pend_q) begin
            maddr_q <= head_i;
            if (left_q == '0) begin
              dbusy_q <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              req_q   <= 1'b1;
              state_q <= S_MDMA;
            end
          end else begin
            src_q   <= head_i;
            state_q <= S_IDLE;
          end
        end
        S_MDMA: if (mdma_ack_i) begin
          left_q <= left_q - NW_W'(1);
          if (left_q == NW_W'(1)) begin
            req_q   <= 1'b0;
            dbusy_q <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        S_ENG: if (eng_done_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign dma_busy_o  = dbusy_q;
  assign eng_start_o = start_q;
  assign eng_nblk_o  = nblk_q;
  assign eng_src_o   = src_q;
  assign mdma_req_o  = req_q;
  assign mdma_dir_o  = dir_q;
  assign mdma_addr_o = maddr_q;
  assign key_load_o  = kld_q;
  assign key_slot_o  = slot_q;
  assign key_tbl_o   = tbl_q;
  assign key_ram_o   = ram_q;
endmodule

// File: rtl/cq_interp.sv
module cq_interp
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int BLK_W = 12,
  parameter int NW_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [31:0]      cmd_data_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             irq_clr_i,
  input  logic [IRQ_W-1:0] irq_clr_mask_i,
  output logic             eng_busy_o,
  output logic             q_empty_o,
  output logic             dma_busy_o,
  output logic [IRQ_W-1:0] irq_stat_o,
  output logic             irq_o,
  output logic             eng_start_o,
  output logic [BLK_W:0]   eng_nblk_o,
  output logic [31:0]      eng_src_o,
  input  logic             eng_done_i,
  output logic             mdma_req_o,
  output logic             mdma_dir_o,
  output logic [31:0]      mdma_addr_o,
  input  logic             mdma_ack_i,
  output logic             key_load_o,
  output logic [2:0]       key_slot_o,
  output logic             key_tbl_sel_o,
  output logic             key_ram_sel_o
);
  logic [31:0]      head;
  logic             q_empty, q_full, pop;
  logic [IRQ_W-1:0] seq_set, irq_set;

  cq_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (cmd_wr_i),
    .data_i (cmd_data_i),
    .pop_i  (pop),
    .data_o (head),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  cq_seq #(.BLK_W(BLK_W), .NW_W(NW_W)) u_seq (
    .clk_i, .rst_ni,
    .head_i     (head),
    .empty_i    (q_empty),
    .pop_o      (pop),
    .set_o      (seq_set),
    .busy_o     (eng_busy_o),
    .dma_busy_o (dma_busy_o),
    .eng_start_o, .eng_nblk_o, .eng_src_o, .eng_done_i,
    .mdma_req_o, .mdma_dir_o, .mdma_addr_o, .mdma_ack_i,
    .key_load_o, .key_slot_o,
    .key_tbl_o  (key_tbl_sel_o),
    .key_ram_o  (key_ram_sel_o)
  );

  always_comb begin
    irq_set = seq_set;
    irq_set[IRQ_OVF] = cmd_wr_i & q_full;
  end

  cq_irq #(.W(IRQ_W)) u_irq (
    .clk_i, .rst_ni,
    .set_i      (irq_set),
    .clr_i      (irq_clr_i),
    .clr_mask_i (irq_clr_mask_i),
    .en_i       (irq_en_i),
    .stat_o     (irq_stat_o),
    .irq_o      (irq_o)
  );

  assign q_empty_o = q_empty;
endmodule

// File: rtl/cq_interp_chk.sv
module cq_interp_chk
  import cq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr_i,
  input logic             irq_clr_i,
  input logic [IRQ_W-1:0] irq_clr_mask_i,
  input logic [IRQ_W-1:0] irq_stat_o,
  input logic [IRQ_W-1:0] irq_set,
  input logic             q_full,
  input logic             q_empty_o,
  input logic             dma_busy_o,
  input logic             eng_start_o,
  input logic             mdma_req_o,
  input logic             mdma_ack_i
);
  assert_ovf_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && q_full) |=> irq_stat_o[IRQ_OVF]);

  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  assert_req_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdma_req_o |-> dma_busy_o);

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdma_req_o && !mdma_ack_i) |=> mdma_req_o);

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && (&irq_clr_mask_i) && (irq_set == '0)) |=> (irq_stat_o == '0));

  assert_empty_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_empty_o && !cmd_wr_i) |=> q_empty_o);
endmodule

bind cq_interp cq_interp_chk u_chk (
  .clk_i, .rst_ni, .cmd_wr_i, .irq_clr_i, .irq_clr_mask_i, .irq_stat_o,
  .irq_set, .q_full, .q_empty_o, .dma_busy_o, .eng_start_o, .mdma_req_o, .mdma_ack_i
);

// File: tb/test_cq_interp.sv
module test_cq_interp;
  localparam int LAT = 176;

  logic clk = 1'b0, rst_n = 1'b1;
  logic cmd_wr = 1'b0, irq_clr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [7:0] irq_en = 8'h33, irq_clr_mask = '0;
  logic eng_busy, q_empty, dma_busy, irq, eng_start, eng_done = 1'b0;
  logic [7:0] irq_stat;
  logic [12:0] eng_nblk;
  logic [31:0] eng_src, mdma_addr;
  logic mdma_req, mdma_dir, mdma_ack = 1'b0, key_load, key_tbl, key_ram;
  logic [2:0] key_slot;

  int tests = 0, fails = 0, eng_left = 0;
  int n_start = 0, n_key = 0, n_words = 0;
  logic [12:0] last_nblk = '0;
  logic [31:0] last_src = '0, last_maddr = '0;
  logic last_dir = 1'b0, last_tbl = 1'b0, last_ram = 1'b0;
  logic [2:0] last_slot = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  cq_interp i_cq_interp (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_clr_mask_i(irq_clr_mask),
    .eng_busy_o(eng_busy), .q_empty_o(q_empty), .dma_busy_o(dma_busy),
    .irq_stat_o(irq_stat), .irq_o(irq), .eng_start_o(eng_start),
    .eng_nblk_o(eng_nblk), .eng_src_o(eng_src), .eng_done_i(eng_done),
    .mdma_req_o(mdma_req), .mdma_dir_o(mdma_dir), .mdma_addr_o(mdma_addr),
    .mdma_ack_i(mdma_ack), .key_load_o(key_load), .key_slot_o(key_slot),
    .key_tbl_sel_o(key_tbl), .key_ram_sel_o(key_ram)
  );

  // cipher stub: 176 cycles per block
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) eng_left <= LAT * int'(eng_nblk);
    else if (eng_left != 0) begin
      if (eng_left == 1) eng_done <= 1'b1;
      eng_left <= eng_left - 1;
    end
  end

  // memory stub: random acknowledge gaps
  always @(posedge clk) mdma_ack <= mdma_req && ($urandom_range(0, 1) == 1);

  always @(posedge clk) begin
    if (eng_start) begin n_start <= n_start + 1; last_nblk <= eng_nblk; last_src <= eng_src; end
    if (key_load) begin
      n_key <= n_key + 1; last_slot <= key_slot; last_tbl <= key_tbl; last_ram <= key_ram;
    end
    if (mdma_req && mdma_ack) begin n_words <= n_words + 1; last_maddr <= mdma_addr; last_dir <= mdma_dir; end
  end

  function automatic logic [31:0] w_eng(input int f);
    return (32'h0E << 26) | 32'(f & 12'hFFF);
  endfunction
  function automatic logic [31:0] w_setup();
    return 32'h10 << 26;
  endfunction
  function automatic logic [31:0] w_done();
    return 32'h11 << 26;
  endfunction
  function automatic logic [31:0] w_key(input int slot, input bit tbl, input bit ram, input bit idb);
    return (32'h15 << 26) | (32'(tbl) << 24) | (32'(ram) << 23) | (32'(idb) << 20) | (32'(slot & 7) << 17);
  endfunction
  function automatic logic [31:0] w_mdma(input bit dir, input int n);
    return (32'h22 << 26) | (32'(dir) << 25) | (32'(n & 13'h1FFF) << 12);
  endfunction
  function automatic bit known_op(input logic [5:0] o);
    return o inside {6'h0E, 6'h10, 6'h11, 6'h15, 6'h22};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!(q_empty && !eng_busy && !dma_busy)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); irq_clr = 1'b1; irq_clr_mask = 8'hFF;
    @(negedge clk); irq_clr = 1'b0; irq_clr_mask = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0, k0, m0;
    logic [31:0] rnd;
    rnd = $urandom(32'h5EED);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(q_empty), 1);
    chk("R1 busy", 32'({eng_busy, dma_busy, irq}), 0);
    chk("R1 status", 32'(irq_stat), 0);

    // R4 start engine with 3 blocks, next word waits
    s0 = n_start; k0 = n_key;
    push(w_eng(2)); push(w_key(3, 1, 0, 1));
    repeat (100) @(negedge clk);
    chk("R4 busy while running", 32'(eng_busy), 1);
    chk("R4 no decode while running", 32'(n_key - k0), 0);
    chk("R10 queue holds word", 32'(q_empty), 0);
    wait_idle();
    chk("R4 nblk", 32'(last_nblk), 3);
    chk("R4 one start", 32'(n_start - s0), 1);
    chk("R7 slot after engine", 32'({last_tbl, last_ram, last_slot}), 32'h13);

    // R3 operand resembling memory-copy opcode
    m0 = n_words;
    push(w_setup()); push(32'h8800_1005); push(w_eng(0));
    wait_idle();
    chk("R3 source address", last_src, 32'h8800_1005);
    chk("R3 no copy", 32'(n_words - m0), 0);
    chk("R3 no error", 32'(irq_stat), 0);

    // R2 overflow: six key loads while engine runs
    k0 = n_key;
    push(w_eng(1));
    for (int s = 0; s < 6; s++) push(w_key(s, 0, 1, 1));
    chk("R2 overflow flag", 32'(irq_stat[1]), 1);
    wait_idle();
    chk("R2 five loads", 32'(n_key - k0), 5);
    chk("R2 last slot", 32'(last_slot), 4);
    chk("R9 irq asserted", 32'(irq), 1);
    irq_en = 8'h0C;
    @(negedge clk);
    chk("R9 masked", 32'(irq), 0);
    irq_en = 8'h33;
    clr_all();
    chk("R9 cleared", 32'(irq_stat), 0);

    // R8 unknown opcode then valid; R7 bad id
    k0 = n_key;
    push(32'h3F00_0000); push(w_key(6, 1, 1, 1));
    wait_idle();
    chk("R8 error bit", 32'(irq_stat), 32'h01);
    chk("R8 queue drains", 32'(n_key - k0), 1);
    clr_all();
    push(w_key(2, 0, 0, 0));
    wait_idle();
    chk("R7 bad id error", 32'(irq_stat), 32'h01);
    chk("R7 bad id no load", 32'(n_key - k0), 1);
    clr_all();

    // R6 busy from acceptance, before operand
    m0 = n_words;
    push(w_mdma(1, 4));
    repeat (4) @(negedge clk);
    chk("R6 busy before operand", 32'({dma_busy, eng_busy, mdma_req}), 32'b110);
    push(32'h0000_4000);
    wait_idle();
    chk("R6 words", 32'(n_words - m0), 4);
    chk("R6 dir addr", last_maddr ^ 32'(last_dir), 32'h0000_4001);
    chk("R6 done bit", 32'(irq_stat), 32'h20);
    clr_all();
    push(w_mdma(0, 0)); push(32'h1234_0000);
    wait_idle();
    chk("R6 zero count", 32'({irq_stat, 8'(n_words - m0)}), {8'h20, 8'd4});
    clr_all();

    // random mix
    for (int i = 0; i < 30; i++) begin
      int kind, f, sl;
      bit b1, b2;
      logic [31:0] a;
      logic [5:0] o;
      kind = int'($urandom_range(0, 5));
      f = int'($urandom_range(0, 7));
      sl = int'($urandom_range(0, 7));
      b1 = 1'($urandom); b2 = 1'($urandom);
      a = $urandom;
      s0 = n_start; k0 = n_key; m0 = n_words;
      case (kind)
        0: begin push(w_eng(f)); wait_idle(); chk("R4 rand nblk", 32'(last_nblk), 32'(f + 1)); end
        1: begin push(w_setup()); push(a); push(w_eng(0)); wait_idle(); chk("R3 rand src", last_src, a); end
        2: begin
          push(w_key(sl, b1, b2, 1)); wait_idle();
          chk("R7 rand key", 32'({last_tbl, last_ram, last_slot}), 32'({b1, b2, 3'(sl)}));
        end
        3: begin
          push(w_mdma(b1, f)); push(a); wait_idle();
          chk("R6 rand words", 32'(n_words - m0), 32'(f));
          if (f != 0) chk("R6 rand addr dir", {last_maddr[31:1], last_dir}, {a[31:1], b1});
          chk("R6 rand done", 32'(irq_stat), 32'h20);
        end
        4: begin push(w_done()); wait_idle(); chk("R5 xfer done", 32'(irq_stat), 32'h10); end
        default: begin
          do o = 6'($urandom); while (known_op(o));
          push({o, 26'($urandom)}); wait_idle();
          chk("R8 rand unknown", 32'(irq_stat), 32'h01);
        end
      endcase
      clr_all();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule